// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core. It arbitrates five interrupt request pins:

- one non-maskable request;
- one edge-latched maskable request;
- two level-sensitive maskable requests;
- one external-vector request, whose restart opcode comes from the requesting device.

The core tells the block when an instruction has finished by pulsing `boundary`. In that same cycle the block decides whether to interrupt. If it does, it raises `take` together with a 16-bit call address, or it raises `ext_vec` to say that the address must come from the device.

The core drives the controller with four strobes. Two of them enable and disable interrupts. `cfg_wr` writes a packed mask/control byte. `stat_rd` returns a packed status byte holding the masks, the enable flag, the pending requests and the synchronized serial input. The controller also holds the serial output latch that the same control byte writes.

Every pin, including the serial input, passes through a synchronizer of `SYNC_STAGES` flops. Edge detection on the two edge-sensitive requests happens after the synchronizer.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all three masks read as 1, the enable flag is 0, both edge latches are clear and `ser_out` is 0. With `ser_in` low, a status read returns 8'h07.
- R2: At a boundary, priority from highest to lowest is `req_nm`, `req_edge`, `req_hi`, `req_lo`, `req_ext`. The call addresses are VEC_BASE plus 16'h0024 (`req_nm`), 16'h003C (`req_edge`), 16'h0034 (`req_hi`) and 16'h002C (`req_lo`).
- R3: When `req_ext` wins, `take` and `ext_vec` are 1 and `vec_addr` is 0.
- R4: `take` is asserted only in a cycle with `boundary` high. Outside such a cycle, `take`, `ext_vec` and `vec_addr` are all 0.
- R5: The four maskable requests need the enable flag set. `ien_set` sets the flag and `ien_clr` clears it. Accepting any maskable request clears the flag, and this clear wins over an `ien_set` in the same cycle. Accepting `req_nm` leaves the flag unchanged.
- R6: A `cfg_wr` with bit3 = 1 loads bits 2..0 as the masks for `req_edge`, `req_hi` and `req_lo` respectively, where 1 means blocked. With bit3 = 0 the masks are unchanged.
- R7: A rising edge on `req_edge` sets its pending latch whatever the masks and the enable flag are. The latch clears when that request is accepted, or on a `cfg_wr` with bit4 = 1. A new edge in the same cycle wins over the clear.
- R8: `req_nm` is accepted only when a latched rising edge exists and the pin is still high. Acceptance clears the latch. The request cannot be accepted again until the pin has gone low and risen again.
- R9: `ser_out` loads `cfg_data` bit7 only on a `cfg_wr` with bit6 = 1. Otherwise it holds its value.
- R10: While `stat_rd` is high, `stat_data` is {synced `ser_in`, `req_edge` pending, synced `req_hi`, synced `req_lo`, enable flag, masks[2:0]}. While `stat_rd` is low, `stat_data` is 0.
- R11: `req_hi`, `req_lo` and `req_ext` are not latched. Once a pin is low after synchronization, it no longer requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_nm | input | 1 | Non-maskable request, edge plus level |
| req_edge | input | 1 | Maskable request, rising-edge latched |
| req_hi | input | 1 | Maskable level request, upper priority |
| req_lo | input | 1 | Maskable level request, lower priority |
| req_ext | input | 1 | Maskable level request, device supplies the vector |
| ser_in | input | 1 | Serial input line, reported in the status byte |
| boundary | input | 1 | Instruction-boundary sample strobe |
| ien_set | input | 1 | Enable-interrupts command |
| ien_clr | input | 1 | Disable-interrupts command |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte |
| stat_rd | input | 1 | Status byte read strobe |
| stat_data | output | 8 | Status byte |
| take | output | 1 | Interrupt accepted this boundary |
| vec_addr | output | 16 | Call address of the accepted request |
| ext_vec | output | 1 | Accepted request needs an external vector |
| ser_out | output | 1 | Serial output latch |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and a vector base of zero. It waits `SYNC_STAGES`+2 cycles after every pin change, so that each edge is latched before the next boundary. With these defaults the bench can compare the absolute vector values directly. It can also reach the same-cycle collision between an acceptance and the enable command, and the stale-edge cases: the non-maskable pin held high after acceptance, and an edge latched while masked and then cleared by the control byte.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_BASE    = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_nm,
  input  logic        req_edge,
  input  logic        req_hi,
  input  logic        req_lo,
  input  logic        req_ext,
  input  logic        ser_in,
  input  logic        boundary,
  input  logic        ien_set,
  input  logic        ien_clr,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_data,
  input  logic        stat_rd,
  output logic [7:0]  stat_data,
  output logic        take,
  output logic [15:0] vec_addr,
  output logic        ext_vec,
  output logic        ser_out
);
  localparam int NPIN = 6;
  localparam int NREQ = 5;
  localparam logic [15:0] VEC_NM   = VEC_BASE + 16'd36;
  localparam logic [15:0] VEC_EDGE = VEC_BASE + 16'd60;
  localparam logic [15:0] VEC_HI   = VEC_BASE + 16'd52;
  localparam logic [15:0] VEC_LO   = VEC_BASE + 16'd44;

  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] syn;
  logic s_nm, s_edge, s_hi, s_lo, s_ext, s_ser;
  logic prev_nm, prev_edge;
  logic [2:0] mask;
  logic ien, pend75, nm_lat;
  logic [NREQ-1:0] req, grant;
  logic cfg_spare_unused;

  assign cfg_spare_unused = cfg_data[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {ser_in, req_ext, req_lo, req_hi, req_edge, req_nm};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign syn = sync_q[SYNC_STAGES-1];
  assign {s_ser, s_ext, s_lo, s_hi, s_edge, s_nm} = syn;

  assign req   = {ien & s_ext, ien & ~mask[0] & s_lo, ien & ~mask[1] & s_hi,
                  ien & ~mask[2] & pend75, nm_lat & s_nm};
  assign grant = req & (~req + 5'd1);
  assign take  = boundary & (|req);

  always_comb begin
    vec_addr = '0;
    ext_vec  = 1'b0;
    if (take) begin
      if (grant[0])      vec_addr = VEC_NM;
      else if (grant[1]) vec_addr = VEC_EDGE;
      else if (grant[2]) vec_addr = VEC_HI;
      else if (grant[3]) vec_addr = VEC_LO;
      else               ext_vec  = 1'b1;
    end
  end

  assign stat_data = stat_rd ? {s_ser, pend75, s_hi, s_lo, ien, mask} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nm   <= 1'b0;
      prev_edge <= 1'b0;
      mask      <= 3'b111;
      ien       <= 1'b0;
      pend75    <= 1'b0;
      nm_lat    <= 1'b0;
      ser_out   <= 1'b0;
    end else begin
      prev_nm   <= s_nm;
      prev_edge <= s_edge;
      if (cfg_wr && cfg_data[3]) mask <= cfg_data[2:0];
      if (cfg_wr && cfg_data[6]) ser_out <= cfg_data[7];
      if (take && !grant[0])     ien <= 1'b0;
      else if (ien_set)          ien <= 1'b1;
      else if (ien_clr)          ien <= 1'b0;
      if (s_edge && !prev_edge)  pend75 <= 1'b1;
      else if ((take && grant[1]) || (cfg_wr && cfg_data[4])) pend75 <= 1'b0;
      if (take && grant[0])      nm_lat <= 1'b0;
      else if (s_nm && !prev_nm) nm_lat <= 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        cfg_wr,
  input logic [7:0]  cfg_data,
  input logic        take,
  input logic [15:0] vec_addr,
  input logic        ext_vec,
  input logic        ser_out,
  input logic        ien,
  input logic [2:0]  mask,
  input logic        pend75,
  input logic        s_nm
);
  assert_take_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> boundary);
  assert_ext_no_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_vec |-> (take && vec_addr == 16'h0000));
  assert_masked_take_clears_ien_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr != 16'h0024) |=> !ien);
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_data[3]) |=> $stable(mask));
  assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend75 && !(cfg_wr && cfg_data[4]) && !(take && vec_addr == 16'h003C)) |=> pend75);
  assert_nm_needs_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr == 16'h0024) |-> s_nm);
  assert_ser_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_data[6]) |=> $stable(ser_out));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .cfg_wr(cfg_wr),
  .cfg_data(cfg_data), .take(take), .vec_addr(vec_addr), .ext_vec(ext_vec),
  .ser_out(ser_out), .ien(ien), .mask(mask), .pend75(pend75), .s_nm(s_nm)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  localparam int SYNC_STAGES = 2;
  localparam int SETTLE = SYNC_STAGES + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_nm = 0, req_edge = 0, req_hi = 0, req_lo = 0, req_ext = 0, ser_in = 0;
  logic boundary = 0, ien_set = 0, ien_clr = 0, cfg_wr = 0, stat_rd = 0;
  logic [7:0] cfg_data = '0;
  logic [7:0] stat_data;
  logic take, ext_vec, ser_out;
  logic [15:0] vec_addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_nm(req_nm), .req_edge(req_edge),
    .req_hi(req_hi), .req_lo(req_lo), .req_ext(req_ext), .ser_in(ser_in),
    .boundary(boundary), .ien_set(ien_set), .ien_clr(ien_clr),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .stat_rd(stat_rd),
    .stat_data(stat_data), .take(take), .vec_addr(vec_addr),
    .ext_vec(ext_vec), .ser_out(ser_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd(input string tag, input logic et, input logic [15:0] ev, input logic ee);
    @(negedge clk);
    boundary = 1'b1;
    #1;
    chk({tag, " take"}, take, et);
    chk({tag, " vec"}, vec_addr, ev);
    chk({tag, " ext"}, ext_vec, ee);
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] exp);
    @(negedge clk);
    stat_rd = 1'b1;
    #1;
    chk(tag, stat_data, exp);
    stat_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_data = '0;
  endtask

  task automatic en();
    @(negedge clk); ien_set = 1'b1;
    @(negedge clk); ien_set = 1'b0;
  endtask

  task automatic dis();
    @(negedge clk); ien_clr = 1'b1;
    @(negedge clk); ien_clr = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ser_out", ser_out, 0);
    chk("R10 idle status", stat_data, 8'h00);
    rd("R1 status", 8'h07);
    req_lo = 1; tick(SETTLE);
    bnd("R1 masked+disabled", 0, 16'h0, 0);
    req_lo = 0; tick(SETTLE);
  endtask

  task automatic t_nonmask();
    req_nm = 1; tick(SETTLE);
    bnd("R8 first", 1, 16'h0024, 0);
    bnd("R8 held no rearm", 0, 16'h0, 0);
    req_nm = 0; tick(SETTLE);
    req_nm = 1; tick(SETTLE);
    bnd("R8 rearmed", 1, 16'h0024, 0);
    req_nm = 0; tick(SETTLE);
  endtask

  task automatic t_level();
    wr(8'h08); en();
    rd("R6 unmasked enabled", 8'h08);
    req_lo = 1; tick(SETTLE);
    rd("R10 lo pending", 8'h18);
    bnd("R2 lo vec", 1, 16'h002C, 0);
    rd("R5 ien cleared", 8'h10);
    bnd("R5 blocked", 0, 16'h0, 0);
    req_lo = 0; tick(SETTLE);
  endtask

  task automatic t_prio_levels();
    req_hi = 1; req_lo = 1; req_ext = 1; tick(SETTLE);
    en(); bnd("R2 hi first", 1, 16'h0034, 0);
    req_hi = 0; tick(SETTLE);
    en(); bnd("R11 lo after hi drops", 1, 16'h002C, 0);
    req_lo = 0; tick(SETTLE);
    en(); bnd("R3 ext", 1, 16'h0000, 1);
    req_ext = 0; tick(SETTLE);
    en(); bnd("R11 nothing left", 0, 16'h0, 0);
    dis();
  endtask

  task automatic t_masks();
    en(); wr(8'h09);
    req_lo = 1; tick(SETTLE);
    bnd("R6 lo masked", 0, 16'h0, 0);
    rd("R10 masked pending", 8'h19);
    req_lo = 0; tick(SETTLE);
    wr(8'h07);
    rd("R6 no mask-set", 8'h09);
  endtask

  task automatic t_edge();
    wr(8'h0F);
    req_edge = 1; tick(SETTLE); req_edge = 0; tick(SETTLE);
    rd("R7 latched while masked", 8'h4F);
    bnd("R7 masked", 0, 16'h0, 0);
    wr(8'h08);
    bnd("R7 delivered", 1, 16'h003C, 0);
    rd("R7 cleared on take", 8'h00);
    req_edge = 1; tick(SETTLE); req_edge = 0; tick(SETTLE);
    rd("R7 latched while disabled", 8'h40);
    en(); bnd("R7 delivered after enable", 1, 16'h003C, 0);
    req_edge = 1; tick(SETTLE); req_edge = 0; tick(SETTLE);
    wr(8'h10);
    rd("R7 bit4 clear", 8'h00);
    en(); bnd("R7 cleared not delivered", 0, 16'h0, 0);
  endtask

  task automatic t_all();
    req_nm = 1; req_edge = 1; req_hi = 1; req_lo = 1; req_ext = 1; tick(SETTLE);
    bnd("R2 nm over all", 1, 16'h0024, 0);
    rd("R5 nm keeps ien", 8'h78);
    bnd("R2 edge second", 1, 16'h003C, 0);
    en(); bnd("R2 hi third", 1, 16'h0034, 0);
    req_nm = 0; req_edge = 0; req_hi = 0; req_lo = 0; req_ext = 0; tick(SETTLE);
  endtask

  task automatic t_gating();
    en(); req_lo = 1; tick(SETTLE);
    chk("R4 no boundary take", take, 0);
    chk("R4 no boundary vec", vec_addr, 16'h0);
    bnd("R4 boundary", 1, 16'h002C, 0);
    en(); dis();
    bnd("R5 disabled", 0, 16'h0, 0);
    rd("R5 disabled status", 8'h10);
    en();
    @(negedge clk); boundary = 1; ien_set = 1; #1;
    chk("R5 collide take", take, 1);
    @(negedge clk); boundary = 0; ien_set = 0;
    rd("R5 take beats set", 8'h10);
    req_lo = 0; tick(SETTLE);
  endtask

  task automatic t_serial();
    wr(8'h80); chk("R9 no enable", ser_out, 0);
    wr(8'hC0); chk("R9 set", ser_out, 1);
    wr(8'h80); chk("R9 hold", ser_out, 1);
    wr(8'h40); chk("R9 clear", ser_out, 0);
    ser_in = 1; tick(SETTLE);
    rd("R10 serial in", 8'h80);
    ser_in = 0; tick(SETTLE);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_nonmask();
    t_level();
    t_prio_levels();
    t_masks();
    t_edge();
    t_all();
    t_gating();
    t_serial();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule